// File: doc/BRIEF.md
# DSP Program Memory Loader

This block is the host-facing register front end of an audio signal processor. It loads the processor's program store and its coefficient/data store. The host cannot write a 64-bit instruction word in a single access. Instead it fills a 32-word staging buffer with 16-bit values and then writes one command word. That command gives a start entry, a word count and a target slot, and a small engine copies the staged words into one 16-bit quarter ("lane") of consecutive entries of one of two 256-entry, 64-bit program memories. A full instruction is therefore assembled from four commits, one per lane, and each commit leaves the other three lanes untouched.

A second path writes the data memory through an address register that steps forward on its own. The host loads a 32-bit address in two halves and then streams words through a single data register. The block drives the write strobe, address and data towards the external data RAM, and it raises the strobe only for addresses inside the two implemented windows. A status register reports whether a commit is still running, and a side port reads back any program memory entry in full.

All host accesses use a synchronous 16-bit bus with a word offset, a write strobe and a read strobe. Read data is registered.

Top module: `dsp_prog_loader`

## Requirements
- R1: After reset both program memories read zero at every entry, the status word reads 0, the data address is 0 and the data write strobe is low.
- R2: Word offsets 0x20 to 0x3F write staging word (offset - 0x20) and read it back; the read value appears on `bus_rdata` at the first clock edge where `bus_rd` is high, and stays there until the next read.
- R3: A write to offset 0x03 is a commit command. Bits 15:13 are the slot and bits 12:8 are the count. Bits 7:0 are the start entry. A slot of 4 to 7 targets memory 1 and 0 to 3 targets memory 0. Slot bits 1:0 give the lane n, which occupies bits 16n+15:16n of the entry. Staged word i goes to entry start+i.
- R4: A count field of 0 copies all 32 staged words.
- R5: Entry indices wrap modulo 256, so a commit running past entry 255 continues at entry 0.
- R6: A commit changes only the selected lane of each entry it touches. The other 48 bits keep their previous value.
- R7: Status (offset 0x01) bit 0 is the busy flag. It is read as 1 on exactly as many consecutive clock edges as the effective count, starting at the first edge after the command write, and it is 0 otherwise. All other status bits read 0.
- R8: While busy is 1, writes to the staging buffer and to the command offset have no effect.
- R9: Offset 0x10 loads bits 31:16 of the data address and offset 0x11 loads bits 15:0. The other half is kept each time.
- R10: A write to offset 0x12 presents the word on `dmem_wdata` with the current address on `dmem_addr` in that same cycle, and then advances the address by one, wrapping at 2^32.
- R11: `dmem_we` is raised only when the current address lies in 0x00000–0x03FFF or 0x1C000–0x1DFFF. A data write to any other address raises no strobe but still advances the address.
- R12: Reads of offsets that are neither the staging buffer nor the status word return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| dmem_we | output | 1 | Data RAM write strobe |
| dmem_addr | output | 32 | Current data RAM word address |
| dmem_wdata | output | 16 | Data RAM write word |
| dbg_bank | input | 1 | Program memory select for the side read port |
| dbg_index | input | 8 | Program memory entry for the side read port |
| dbg_word | output | 64 | Selected program memory entry |

## Verification
The embedded assertions check four things on every cycle. An accepted command must raise busy on the next cycle. A staging word must not change when it is addressed during a commit. Each engine step must leave the three unselected lanes of the target entry as they were. Every data-port write must advance the address by exactly one. The bench scenarios are needed for the rest, which depends on many cycles together: the length of the busy window, the effect of a zero count, wrap-around past entry 255, and the window decoding of the data strobe. The bench checks these by comparing both program memories in full against a reference model after each commit.

// File: rtl/dsp_prog_loader.sv
module dsp_prog_loader #(
  parameter logic [31:0] WIN0_BASE  = 32'h0000_0000,
  parameter logic [31:0] WIN0_WORDS = 32'h0000_4000,
  parameter logic [31:0] WIN1_BASE  = 32'h0001_C000,
  parameter logic [31:0] WIN1_WORDS = 32'h0000_2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [15:0] bus_rdata,
  output logic        dmem_we,
  output logic [31:0] dmem_addr,
  output logic [15:0] dmem_wdata,
  input  logic        dbg_bank,
  input  logic [7:0]  dbg_index,
  output logic [63:0] dbg_word
);
  localparam int LANE_W = 16;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int STAGE  = 32;
  localparam int DEPTH  = 256;
  localparam int CW     = $clog2(STAGE);
  localparam int IW     = $clog2(DEPTH);

  localparam logic [5:0] OFS_STATUS = 6'h01;
  localparam logic [5:0] OFS_CMD    = 6'h03;
  localparam logic [5:0] OFS_AHI    = 6'h10;
  localparam logic [5:0] OFS_ALO    = 6'h11;
  localparam logic [5:0] OFS_DATA   = 6'h12;

  logic [LANE_W-1:0] stage_q [STAGE];
  logic [WORD_W-1:0] pm0 [DEPTH];
  logic [WORD_W-1:0] pm1 [DEPTH];
  logic              busy;
  logic [CW-1:0]     cnt;
  logic [CW:0]       len_q;
  logic [2:0]        slot_q;
  logic [IW-1:0]     start_q;
  logic [31:0]       daddr;
  logic [15:0]       rdata_q;

  wire wr_stage = bus_wr && bus_addr[5];
  wire wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
  wire wr_ahi   = bus_wr && (bus_addr == OFS_AHI);
  wire wr_alo   = bus_wr && (bus_addr == OFS_ALO);
  wire wr_data  = bus_wr && (bus_addr == OFS_DATA);

  wire [IW-1:0]     cur_idx   = start_q + IW'(cnt);
  wire [5:0]        lane_sh   = {slot_q[1:0], 4'b0000};
  wire [WORD_W-1:0] lane_mask = {{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << lane_sh;
  wire [WORD_W-1:0] cur_old   = slot_q[2] ? pm1[cur_idx] : pm0[cur_idx];
  wire [WORD_W-1:0] cur_new   = (cur_old & ~lane_mask) |
                                ({{(WORD_W-LANE_W){1'b0}}, stage_q[cnt]} << lane_sh);
  wire              last_step = ({1'b0, cnt} == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGE; i++) stage_q[i] <= '0;
    end else if (wr_stage && !busy) begin
      stage_q[bus_addr[4:0]] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pm0[i] <= '0;
        pm1[i] <= '0;
      end
      busy    <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      slot_q  <= '0;
      start_q <= '0;
    end else if (busy) begin
      if (slot_q[2]) pm1[cur_idx] <= cur_new;
      else           pm0[cur_idx] <= cur_new;
      cnt <= cnt + 1'b1;
      if (last_step) busy <= 1'b0;
    end else if (wr_cmd) begin
      slot_q  <= bus_wdata[15:13];
      len_q   <= (bus_wdata[12:8] == 5'd0) ? (CW+1)'(STAGE) : {1'b0, bus_wdata[12:8]};
      start_q <= bus_wdata[7:0];
      cnt     <= '0;
      busy    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      daddr <= '0;
    end else if (wr_ahi) begin
      daddr[31:16] <= bus_wdata;
    end else if (wr_alo) begin
      daddr[15:0] <= bus_wdata;
    end else if (wr_data) begin
      daddr <= daddr + 32'd1;
    end
  end

  wire in_win = ((daddr - WIN0_BASE) < WIN0_WORDS) || ((daddr - WIN1_BASE) < WIN1_WORDS);

  assign dmem_we    = wr_data && in_win;
  assign dmem_addr  = daddr;
  assign dmem_wdata = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (bus_addr[5])                 rdata_q <= stage_q[bus_addr[4:0]];
      else if (bus_addr == OFS_STATUS) rdata_q <= {15'd0, busy};
      else                             rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign dbg_word  = dbg_bank ? pm1[dbg_index] : pm0[dbg_index];

  p_cmd_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy) |=> busy);

  p_stage_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stage && busy) |=> (stage_q[$past(bus_addr[4:0])] == $past(stage_q[bus_addr[4:0]])));

  p_lane_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((((($past(slot_q[2]) ? pm1[$past(cur_idx)] : pm0[$past(cur_idx)])) ^ $past(cur_old))
               & ~$past(lane_mask)) == '0));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (daddr == $past(daddr) + 32'd1));
endmodule

// File: tb/dsp_prog_loader_test.sv
`timescale 1ns/1ps
module dsp_prog_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        dmem_we;
  logic [31:0] dmem_addr;
  logic [15:0] dmem_wdata;
  logic        dbg_bank = 1'b0;
  logic [7:0]  dbg_index = '0;
  logic [63:0] dbg_word;

  int tests = 0;
  int fails = 0;

  logic [63:0] ref0 [256];
  logic [63:0] ref1 [256];
  logic [15:0] stage_ref [32];

  dsp_prog_loader uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dbg_bank(dbg_bank), .dbg_index(dbg_index), .dbg_word(dbg_word)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic compare_mems(input string req);
    int bad = 0;
    logic [63:0] a_bad = '0, e_bad = '0;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 256; i++) begin
        dbg_bank = b[0]; dbg_index = i[7:0];
        #0.001;
        if (dbg_word !== (b == 0 ? ref0[i] : ref1[i])) begin
          if (bad == 0) begin a_bad = dbg_word; e_bad = (b == 0 ? ref0[i] : ref1[i]); end
          bad++;
        end
      end
    end
    check(bad == 0, req, a_bad, e_bad);
    @(negedge clk);
  endtask

  task automatic load_stage(input logic [15:0] seed);
    for (int i = 0; i < 32; i++) begin
      stage_ref[i] = seed ^ (16'h1111 * i[15:0]) ^ {i[7:0], 8'hA5};
      bus_write(6'h20 + i[5:0], stage_ref[i]);
    end
  endtask

  task automatic commit(input logic [2:0] slot, input logic [4:0] len, input logic [7:0] start, input string req);
    int eff = (len == 0) ? 32 : int'(len);
    int busy_n = 0;
    logic [15:0] v;
    for (int i = 0; i < eff; i++) begin
      logic [7:0] idx = start + i[7:0];
      logic [63:0] m = 64'hFFFF << (16 * slot[1:0]);
      logic [63:0] w = {48'd0, stage_ref[i]} << (16 * slot[1:0]);
      if (slot[2]) ref1[idx] = (ref1[idx] & ~m) | w;
      else         ref0[idx] = (ref0[idx] & ~m) | w;
    end
    bus_write(6'h03, {slot, len, start});
    for (int k = 0; k < 40; k++) begin
      bus_read(6'h01, v);
      if (v[0]) busy_n++;
      else break;
    end
    check(busy_n == eff, "R7 busy cycle count", 64'(busy_n), 64'(eff));
    check(v == 16'h0000, "R7 status idle value", 64'(v), 64'h0);
    compare_mems(req);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    bus_read(6'h01, v);
    check(v == 16'h0, "R1 status after reset", 64'(v), 64'h0);
    check(dmem_addr == 32'h0, "R1 data address after reset", 64'(dmem_addr), 64'h0);
    check(dmem_we == 1'b0, "R1 strobe after reset", 64'(dmem_we), 64'h0);
    compare_mems("R1 program memories cleared");
  endtask

  task automatic t_stage_readback;
    logic [15:0] v;
    int bad = 0;
    load_stage(16'h3C5A);
    for (int i = 0; i < 32; i++) begin
      bus_read(6'h20 + i[5:0], v);
      if (v !== stage_ref[i]) bad++;
    end
    check(bad == 0, "R2 staging readback mismatches", 64'(bad), 64'h0);
    @(negedge clk);
    check(bus_rdata == stage_ref[31], "R2 read data held", 64'(bus_rdata), 64'(stage_ref[31]));
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    bus_write(6'h10, 16'hBEEF);
    bus_read(6'h00, v); check(v == 0, "R12 offset 0x00 reads zero", 64'(v), 0);
    bus_read(6'h03, v); check(v == 0, "R12 command offset reads zero", 64'(v), 0);
    bus_read(6'h10, v); check(v == 0, "R12 address high reads zero", 64'(v), 0);
    bus_read(6'h12, v); check(v == 0, "R12 data offset reads zero", 64'(v), 0);
    bus_write(6'h10, 16'h0000);
  endtask

  task automatic t_commits;
    load_stage(16'h1234);
    commit(3'd0, 5'd5, 8'd10, "R3 slot 0 lane 0 memory 0");
    commit(3'd6, 5'd7, 8'd100, "R3 slot 6 lane 2 memory 1");
    load_stage(16'h9E37);
    commit(3'd1, 5'd5, 8'd12, "R6 lane 1 over lane 0 keeps other lanes");
    commit(3'd3, 5'd0, 8'd0, "R4 count zero copies 32 words");
    commit(3'd5, 5'd20, 8'd250, "R5 wrap past entry 255");
    commit(3'd4, 5'd31, 8'd240, "R6 lane 0 of memory 1 keeps lane 1 and 2");
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v;
    int busy_n = 0;
    load_stage(16'h0F0F);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] idx = 8'd64 + i[7:0];
      ref0[idx] = (ref0[idx] & ~(64'hFFFF << 48)) | ({48'd0, stage_ref[i]} << 48);
    end
    bus_write(6'h03, {3'd3, 5'd0, 8'd64});
    bus_write(6'h20, 16'hDEAD);
    bus_write(6'h03, {3'd7, 5'd3, 8'd0});
    for (int k = 0; k < 40; k++) begin
      bus_read(6'h01, v);
      if (v[0]) busy_n++;
      else break;
    end
    check(busy_n == 30, "R8 busy remaining after ignored writes", 64'(busy_n), 64'd30);
    bus_read(6'h20, v);
    check(v == stage_ref[0], "R8 staging write ignored while busy", 64'(v), 64'(stage_ref[0]));
    compare_mems("R8 command ignored while busy");
  endtask

  task automatic data_write(input logic [15:0] d, input bit exp_we, input logic [31:0] exp_a, input string req);
    bus_addr = 6'h12; bus_wdata = d; bus_wr = 1'b1;
    #1;
    check(dmem_we == exp_we, req, 64'(dmem_we), 64'(exp_we));
    check(dmem_addr == exp_a && dmem_wdata == d, "R10 address and word presented",
          {dmem_addr, dmem_wdata, 16'h0}, {exp_a, d, 16'h0});
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_data_port;
    bus_write(6'h11, 16'h3FFE);
    check(dmem_addr == 32'h0000_3FFE, "R9 low half load", 64'(dmem_addr), 64'h3FFE);
    data_write(16'hA001, 1'b1, 32'h0000_3FFE, "R11 strobe in low window");
    data_write(16'hA002, 1'b1, 32'h0000_3FFF, "R11 strobe at top of low window");
    data_write(16'hA003, 1'b0, 32'h0000_4000, "R11 no strobe above low window");
    check(dmem_addr == 32'h0000_4001, "R10 dropped write still advances", 64'(dmem_addr), 64'h4001);
    bus_write(6'h10, 16'h0001);
    check(dmem_addr == 32'h0001_4001, "R9 high half load keeps low half", 64'(dmem_addr), 64'h14001);
    bus_write(6'h11, 16'hBFFF);
    data_write(16'hB001, 1'b0, 32'h0001_BFFF, "R11 no strobe below high window");
    data_write(16'hB002, 1'b1, 32'h0001_C000, "R11 strobe at base of high window");
    bus_write(6'h11, 16'hDFFF);
    data_write(16'hB003, 1'b1, 32'h0001_DFFF, "R11 strobe at top of high window");
    data_write(16'hB004, 1'b0, 32'h0001_E000, "R11 no strobe above high window");
    bus_write(6'h10, 16'hFFFF);
    bus_write(6'h11, 16'hFFFF);
    data_write(16'hC001, 1'b0, 32'hFFFF_FFFF, "R11 no strobe at top address");
    check(dmem_addr == 32'h0, "R10 address wraps to zero", 64'(dmem_addr), 64'h0);
    data_write(16'hC002, 1'b1, 32'h0, "R11 strobe at address zero");
  endtask

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ref0[i] = '0; ref1[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_readback();
    t_unmapped();
    t_commits();
    t_busy_ignore();
    t_data_port();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule